// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Detection

This block recovers bytes from an asynchronous serial line. An external enable pulse arrives at sixteen times the bit rate. On each pulse the block samples the line and recovers frames of one start bit, eight data bits sent least significant bit first, and one stop bit. Each received byte is held in a data register. A set of status flags reports the byte and any trouble with it: data present, idle line, overrun, framing error and parity error.

Software uses a small register port with four addresses. The port holds a mode register (parity and idle-count options), a control register whose bit layout is fixed for compatibility, a status register and the data register. One interrupt output combines the receive conditions and the idle condition, each with its own enable.

Top module: `uart_idle_rx`

## Requirements
- R1: After synchronous reset the mode register (address 0), the control register (address 1) and the status register (address 2) all read 0x00, and `irq` is low.
- R2: The control register at address 1 holds, from bit 7 down to bit 0: transmit interrupt enable, transmit-complete interrupt enable, receive interrupt enable (bit 5), idle interrupt enable (bit 4), transmitter enable, receiver enable (bit 2), wake-up and send-break. All eight bits read back as written. Bits 7, 6, 3, 1 and 0 have no effect on reception or on `irq`.
- R3: While the receiver is enabled, a frame (a low start bit, eight data bits LSB first, a stop bit) is recovered. Each bit is the majority of samples 7, 8 and 9 of its sixteen. The byte is readable at address 3, and status bit 0 (data full) is set.
- R4: A low pulse on the line whose samples 7 to 9 are mostly high is rejected as a false start, and no byte is received.
- R5: A stop bit recovered as 0 sets status bit 3 (framing error). The byte is still stored.
- R6: Mode bit 1 enables parity. When it is set, data bit 7 is the parity bit. With mode bit 0 clear (even parity) the total count of ones in the eight bits must be even; with mode bit 0 set (odd parity) it must be odd. A mismatch sets status bit 4. With mode bit 1 clear no parity error is ever set.
- R7: A byte that completes while data full is set sets status bit 2 (overrun) and is discarded. The data register keeps the earlier byte.
- R8: With mode bit 2 clear, counting of line-high time starts after the start bit. A full frame time (ten bit times) of consecutive high line sets status bit 1 (idle). Trailing ones in the data and the stop bit count toward it.
- R9: With mode bit 2 set, counting of line-high time starts only after the stop bit. A byte ending in ones followed by a short gap does not set the idle flag, while ten bit times of high line after the stop bit do set it.
- R10: The idle flag sets at most once per idle period. After it is cleared it does not set again until another character has been received. No idle flag is raised before the first character after reset.
- R11: While the receiver-enable bit is 0, line activity changes no status flag.
- R12: `irq` is high exactly when (receive interrupt enable and (data full or overrun)) or (idle interrupt enable and idle) holds.
- R13: Reading the status register and then reading the data register clears all status flags. Reading the data register alone clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable pulse at 16x the bit rate |
| rx | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 2 | Register address: 0 mode, 1 control, 2 status, 3 data |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `tick16` is a one-cycle pulse and that the receiver-enable bit only changes through a register write. They also assume that flags fall only through the read sequence and never through a register write. The bench generates `tick16` as a steady every-other-cycle pulse and holds each serial bit for exactly sixteen ticks. It issues only one register access per cycle. It leaves the line high for at least twelve bit times and clears the flags before each scenario, so no idle count carries over from the previous one. Gaps between frames are chosen with margins of half a bit time or more around the ten-bit idle threshold.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // mode register, bits 2..0
    typedef struct packed {
        logic idle_after_stop;
        logic par_en;
        logic par_odd;
    } mode_t;

    // control register, bits 7..0 (fixed layout)
    typedef struct packed {
        logic tx_ie;
        logic txc_ie;
        logic rx_ie;
        logic idle_ie;
        logic tx_en;
        logic rx_en;
        logic wake;
        logic brk;
    } ctrl_t;

    // status register, bits 4..0
    typedef struct packed {
        logic par_err;
        logic frame_err;
        logic overrun;
        logic idle;
        logic full;
    } stat_t;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // xor_all: reduction xor of the whole data field including the parity bit
    function automatic logic parity_mismatch(input logic xor_all, input logic odd);
        return xor_all ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx_s,
    input  logic                 enable,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID = OSR / 2;

    rx_state_e             state;
    logic [CW-1:0]         cnt;
    logic [BW-1:0]         bit_idx;
    logic [1:0]            samp;
    logic [DATA_BITS-1:0]  shreg;
    logic                  maj;

    assign maj  = majority3(samp[0], samp[1], rx_s);
    assign busy = (state != RX_IDLE);
    assign data = shreg;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            samp    <= '0;
            done    <= 1'b0;
            if (rst) begin
                shreg   <= '0;
                stop_ok <= 1'b1;
            end
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!rx_s) begin
                        state <= RX_START;
                        cnt   <= CW'(1);
                    end
                end else begin
                    cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
                    if (cnt == CW'(MID - 1)) samp[0] <= rx_s;
                    if (cnt == CW'(MID))     samp[1] <= rx_s;
                    if (cnt == CW'(MID + 1)) begin
                        case (state)
                            RX_START: if (maj) state <= RX_IDLE;
                            RX_DATA:  shreg <= {maj, shreg[DATA_BITS-1:1]};
                            RX_STOP: begin
                                stop_ok <= maj;
                                done    <= 1'b1;
                                state   <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == CW'(OSR - 1)) begin
                        case (state)
                            RX_START: begin
                                state   <= RX_DATA;
                                bit_idx <= '0;
                            end
                            RX_DATA: begin
                                if (bit_idx == BW'(DATA_BITS - 1)) state <= RX_STOP;
                                else bit_idx <= bit_idx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_idle_det.sv
module uart_idle_det #(
    parameter int LIMIT = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_s,
    input  logic enable,
    input  logic after_stop,
    input  logic busy,
    input  logic char_done,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            hit   <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (char_done) armed <= 1'b1;
            if (!enable || !rx_s || (after_stop && busy)) begin
                cnt <= '0;
            end else if (tick && cnt < W'(LIMIT)) begin
                cnt <= cnt + 1'b1;
                if (cnt == W'(LIMIT - 1) && armed) begin
                    hit   <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [1:0]           addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 byte_done,
    input  logic [DATA_BITS-1:0] byte_data,
    input  logic                 stop_ok,
    input  logic                 idle_hit,
    output logic [REG_W-1:0]     rdata,
    output mode_t                mode_q,
    output ctrl_t                ctrl_q,
    output stat_t                stat_q,
    output logic                 irq
);
    logic [DATA_BITS-1:0] data_q;
    logic                 clr_armed;
    logic                 par_bad;

    assign par_bad = mode_q.par_en && parity_mismatch(^byte_data, mode_q.par_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            ctrl_q    <= '0;
            stat_q    <= '0;
            data_q    <= '0;
            clr_armed <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    ADDR_MODE: mode_q <= mode_t'(wdata[2:0]);
                    ADDR_CTRL: ctrl_q <= ctrl_t'(wdata);
                    default: ;
                endcase
            end
            if (rd_en && addr == ADDR_STAT) clr_armed <= 1'b1;
            if (rd_en && addr == ADDR_DATA && clr_armed) begin
                stat_q    <= '0;
                clr_armed <= 1'b0;
            end
            if (byte_done) begin
                if (stat_q.full) begin
                    stat_q.overrun <= 1'b1;
                end else begin
                    stat_q.full <= 1'b1;
                    data_q      <= byte_data;
                    if (!stop_ok) stat_q.frame_err <= 1'b1;
                    if (par_bad)  stat_q.par_err   <= 1'b1;
                end
            end
            if (idle_hit) stat_q.idle <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            ADDR_MODE: rdata = {5'b0, mode_q};
            ADDR_CTRL: rdata = ctrl_q;
            ADDR_STAT: rdata = {3'b0, stat_q};
            default:   rdata = REG_W'(data_q);
        endcase
    end

    assign irq = (ctrl_q.rx_ie && (stat_q.full || stat_q.overrun)) ||
                 (ctrl_q.idle_ie && stat_q.idle);
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16,
    input  logic        rx,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int IDLE_TICKS = FRAME_BITS * OSR;

    logic                 rx_meta, rx_s;
    logic                 busy, byte_done, stop_ok, idle_hit;
    logic [DATA_BITS-1:0] byte_data;
    mode_t                mode_q;
    ctrl_t                ctrl_q;
    stat_t                stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rx;
            rx_s    <= rx_meta;
        end
    end

    uart_rx_sampler #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_samp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rx_s    (rx_s),
        .enable  (ctrl_q.rx_en),
        .busy    (busy),
        .done    (byte_done),
        .data    (byte_data),
        .stop_ok (stop_ok)
    );

    uart_idle_det #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .rx_s       (rx_s),
        .enable     (ctrl_q.rx_en),
        .after_stop (mode_q.idle_after_stop),
        .busy       (busy),
        .char_done  (byte_done),
        .hit        (idle_hit)
    );

    uart_rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .byte_done (byte_done),
        .byte_data (byte_data),
        .stop_ok   (stop_ok),
        .idle_hit  (idle_hit),
        .rdata     (rdata),
        .mode_q    (mode_q),
        .ctrl_q    (ctrl_q),
        .stat_q    (stat_q),
        .irq       (irq)
    );
endmodule

// File: rtl/uart_idle_rx_chk.sv
module uart_idle_rx_chk
    import uart_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic       rx_s,
    input logic       byte_done,
    input mode_t      mode_q,
    input ctrl_t      ctrl_q,
    input stat_t      stat_q,
    input logic       irq
);
    assert_full_src_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.full) |-> $past(byte_done));

    assert_frame_src_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.frame_err) |-> $past(byte_done));

    assert_parity_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.par_err) |-> $past(mode_q.par_en));

    assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.overrun) |-> $past(stat_q.full));

    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.idle) |-> $past(rx_s, 2));

    assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.rx_en && $past(!ctrl_q.rx_en) && !rd_en && !wr_en) |=> $stable(stat_q));

    assert_irq_enable_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.rx_ie || ctrl_q.idle_ie));

    assert_clear_path_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q.full) |-> $past(rd_en && addr == ADDR_DATA));
endmodule

bind uart_idle_rx uart_idle_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rx_s      (rx_s),
    .byte_done (byte_done),
    .mode_q    (mode_q),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .irq       (irq)
);

// File: tb/tb_uart_idle_rx.sv
`timescale 1ns/1ps
module tb_uart_idle_rx;
    localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks
    localparam logic [1:0] A_MODE = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;
    localparam logic [7:0] S_FULL = 8'h01, S_IDLE = 8'h02, S_OVR = 8'h04,
                           S_FE = 8'h08, S_PE = 8'h10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tick16 <= 1'b0;
        else     tick16 <= ~tick16;
    end

    uart_idle_rx dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rx(rx),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int nclk);
        rx = b;
        repeat (nclk) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
        hold(stop, BIT_CLK);
        rx = 1'b1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        reg_read(A_STAT, d);
        reg_read(A_DATA, d);
    endtask

    task automatic settle();
        hold(1'b1, 12 * BIT_CLK);
        clear_flags();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(A_MODE, d); check("R1 mode", d, 8'h00);
        peek(A_CTRL, d); check("R1 ctrl", d, 8'h00);
        peek(A_STAT, d); check("R1 stat", d, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        reg_write(A_CTRL, 8'hA5);
        peek(A_CTRL, d); check("R2 ctrl readback A5", d, 8'hA5);
        reg_write(A_CTRL, 8'hCB);   // tx/wake/brk bits only, receiver off
        peek(A_CTRL, d); check("R2 ctrl readback CB", d, 8'hCB);
        send_frame(8'h33, 1'b1);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check("R2 tx bits no reception", d, 8'h00);
        check("R2 tx bits no irq", {7'b0, irq}, 8'h00);
        reg_write(A_MODE, 8'h07);
        peek(A_MODE, d); check("R2 mode readback", d, 8'h07);
        reg_write(A_MODE, 8'h00);
        reg_write(A_CTRL, 8'hCF);   // receiver on, other non-receive bits set
        settle();
    endtask

    task automatic t_basic();
        logic [7:0] d;
        logic [7:0] pats [4] = '{8'h5A, 8'h00, 8'h3C, 8'h81};
        foreach (pats[i]) begin
            settle();
            send_frame(pats[i], 1'b1);
            hold(1'b1, BIT_CLK);
            peek(A_STAT, d); check("R3 full flag", d, S_FULL);
            peek(A_DATA, d); check("R3 data byte", d, pats[i]);
            check("R12 no irq without enable", {7'b0, irq}, 8'h00);
        end
        reg_write(A_CTRL, 8'h24);
        check("R12 irq on full", {7'b0, irq}, 8'h01);
        clear_flags();
        peek(A_STAT, d); check("R13 cleared", d, 8'h00);
        check("R12 irq drops", {7'b0, irq}, 8'h00);
        reg_write(A_CTRL, 8'h04);
    endtask

    task automatic t_partial_clear();
        logic [7:0] d;
        settle();
        send_frame(8'h6E, 1'b1);
        hold(1'b1, BIT_CLK);
        reg_read(A_DATA, d); check("R13 data read value", d, 8'h6E);
        peek(A_STAT, d); check("R13 data read alone keeps flag", d, S_FULL);
        clear_flags();
        peek(A_STAT, d); check("R13 sequence clears", d, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        settle();
        reg_write(A_CTRL, 8'h30);   // interrupts enabled, receiver off
        send_frame(8'h42, 1'b1);
        hold(1'b1, 12 * BIT_CLK);
        peek(A_STAT, d); check("R11 disabled no flags", d, 8'h00);
        check("R11 disabled no irq", {7'b0, irq}, 8'h00);
        reg_write(A_CTRL, 8'h04);
    endtask

    task automatic t_false_start();
        logic [7:0] d;
        settle();
        hold(1'b0, 8);              // 4 ticks low only
        hold(1'b1, 12 * BIT_CLK);
        peek(A_STAT, d); check("R4 glitch rejected", d, 8'h00);
    endtask

    task automatic t_framing();
        logic [7:0] d;
        settle();
        send_frame(8'h55, 1'b0);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check("R5 framing error", d, S_FULL | S_FE);
        peek(A_DATA, d); check("R5 byte kept", d, 8'h55);
    endtask

    task automatic parity_case(input logic [7:0] mode, input logic [7:0] b,
                               input logic [7:0] exp, input string req);
        logic [7:0] d;
        reg_write(A_MODE, mode);
        settle();
        send_frame(b, 1'b1);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check(req, d, exp);
    endtask

    task automatic t_parity();
        parity_case(8'h02, 8'h81, S_FULL,        "R6 even ok");
        parity_case(8'h02, 8'h80, S_FULL | S_PE, "R6 even bad");
        parity_case(8'h03, 8'h80, S_FULL,        "R6 odd ok");
        parity_case(8'h03, 8'h81, S_FULL | S_PE, "R6 odd bad");
        parity_case(8'h00, 8'h80, S_FULL,        "R6 disabled");
        reg_write(A_MODE, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        settle();
        send_frame(8'h11, 1'b1);
        hold(1'b1, BIT_CLK);
        send_frame(8'h22, 1'b1);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check("R7 overrun flag", d, S_FULL | S_OVR);
        peek(A_DATA, d); check("R7 first byte kept", d, 8'h11);
        reg_write(A_CTRL, 8'h24);
        check("R12 irq on overrun", {7'b0, irq}, 8'h01);
        reg_write(A_CTRL, 8'h04);
    endtask

    task automatic t_idle();
        logic [7:0] d;
        // count from start bit: trailing ones reach a frame time
        reg_write(A_MODE, 8'h00);
        settle();
        send_frame(8'hFF, 1'b1);
        hold(1'b1, 48);
        send_frame(8'h00, 1'b1);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check("R8 idle after start", d & S_IDLE, S_IDLE);
        // count from stop bit: same pattern, no idle
        reg_write(A_MODE, 8'h04);
        settle();
        send_frame(8'hFF, 1'b1);
        hold(1'b1, 48);
        send_frame(8'h00, 1'b1);
        hold(1'b1, BIT_CLK);
        peek(A_STAT, d); check("R9 no false idle", d & S_IDLE, 8'h00);
        hold(1'b1, 11 * BIT_CLK);
        peek(A_STAT, d); check("R9 true idle", d & S_IDLE, S_IDLE);
        reg_write(A_CTRL, 8'h14);
        check("R12 irq on idle", {7'b0, irq}, 8'h01);
        reg_write(A_CTRL, 8'h04);
        clear_flags();
        hold(1'b1, 24 * BIT_CLK);
        peek(A_STAT, d); check("R10 idle once", d, 8'h00);
        reg_write(A_MODE, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_rw();
        // R10: no idle before first character after reset (ctrl set in t_ctrl_rw)
        begin
            logic [7:0] d;
            peek(A_STAT, d); check("R10 no idle before first byte", d, 8'h00);
        end
        reg_write(A_CTRL, 8'h04);
        t_basic();
        t_partial_clear();
        t_disabled();
        t_false_start();
        t_framing();
        t_parity();
        t_overrun();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule